// File: doc/BRIEF.md
# Duplicate Node Address Detector

This block sits beside a network receiver and runs while a station has a nonzero node address but has not yet enabled its transmitter. For each decoded token it compares the destination address with the node address. When a token aimed at this node is followed within a short time by a response from some other station, the address is already in use, and a sticky duplicate flag is raised.

The block also keeps a small diagnostic status byte. Besides the duplicate flag, the byte holds a sticky token-seen bit, a live receive-activity bit and a sticky own-reconfiguration bit. The sticky bits clear when software reads the byte. A detection-window timer measures the worst-case time needed to find a duplicate. Its length depends on two extended-timeout inputs. The timer pulses an output when a whole window passes with no duplicate found. Software can then trust the address and set transmit enable.

Top module: `dupid_monitor`

## Requirements
- R1: After reset, `stat_byte` is 0x00 and `win_done` is 0.
- R2: A token with `tok_dst` equal to a nonzero `node_addr`, sampled while `tx_en` is 0, arms the detector. A `rsp_vld` sampled on any of the next RSP_TO clock edges sets status bit 0 (duplicate), visible after that edge.
- R3: A response sampled later than RSP_TO edges after the matching token, or a response following a token to another address, leaves bit 0 clear.
- R4: Nothing is detected while `tx_en` is 1 or `node_addr` is 0.
- R5: A `stat_rd` pulse clears bits 0, 1 and 3 after its edge. If a set event is sampled on the same edge, that bit stays set.
- R6: Every `tok_vld` pulse, whatever its address, sets status bit 1 (token seen).
- R7: Status bit 2 copies `rx_act` one edge later, and `stat_rd` does not clear it.
- R8: A `join_evt` sampled while `tx_en` is 1 sets status bit 3 (own reconfiguration). While `tx_en` is 0, `join_evt` has no effect.
- R9: While detection is active, `win_done` pulses for one cycle WIN_TICKS edges after the window starts when `ext_to` is 2'b11, and 2*WIN_TICKS edges after it starts for any other `ext_to` value.
- R10: Writing a different `node_addr` restarts the window from the edge that sees the change, and it drops any armed token.
- R11: A window in which a duplicate was detected ends with no `win_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_addr | input | ADDR_W | Node address register value; 0 means asleep |
| tx_en | input | 1 | Transmit enable; 1 ends detection |
| ext_to | input | 2 | Extended-timeout select; 2'b11 selects the short window |
| tok_vld | input | 1 | One-cycle strobe for a decoded token |
| tok_dst | input | ADDR_W | Destination address of the token |
| rsp_vld | input | 1 | One-cycle strobe for a response seen on the line |
| rx_act | input | 1 | Receive activity level |
| join_evt | input | 1 | Strobe marking that the node joined the network |
| stat_rd | input | 1 | Status read strobe |
| stat_byte | output | 8 | Status: bit0 duplicate, bit1 token seen, bit2 receive activity, bit3 own reconfiguration |
| win_done | output | 1 | One-cycle pulse when a window ends with no duplicate |

## Verification
Every status bit and the window pulse is registered. A result therefore appears just after the edge that samples its cause: the response edge for the duplicate bit, the strobe edge for the token-seen and reconfiguration bits, and one edge after the activity input for bit 2. The window pulse appears after the edge that completes the count, WIN_TICKS or 2*WIN_TICKS edges after the restart edge. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next edge, so each check looks at the cycle in which its result is due. Window lengths are counted in edges from the address-change edge and compared exactly.

// File: rtl/dupid_pkg.sv
package dupid_pkg;
  localparam int DUP_BIT = 0;
  localparam int TOK_BIT = 1;
  localparam int RXA_BIT = 2;
  localparam int RCN_BIT = 3;

  typedef struct packed {
    logic rcn;
    logic rxa;
    logic tok;
    logic dup;
  } stat_t;
endpackage

// File: rtl/dupid_match.sv
module dupid_match #(
  parameter int ADDR_W = 8,
  parameter int RSP_TO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              addr_chg,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              tok_vld,
  input  logic [ADDR_W-1:0] tok_dst,
  input  logic              rsp_vld,
  output logic              dup_evt,
  output logic              armed
);
  localparam int CW = $clog2(RSP_TO + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;

  always_comb begin
    hit     = tok_vld && active && (tok_dst == node_addr);
    armed   = (cnt_q != '0);
    dup_evt = rsp_vld && armed && active && !addr_chg;
    if (!active || addr_chg) cnt_d = '0;
    else if (hit)            cnt_d = CW'(RSP_TO);
    else if (armed)          cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dupid_window.sv
module dupid_window #(
  parameter int WIN_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       addr_chg,
  input  logic [1:0] ext_to,
  input  logic       dup_evt,
  output logic       win_done
);
  localparam int LIM_LONG = 2 * WIN_TICKS;
  localparam int CW       = $clog2(LIM_LONG + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          seen_q, seen_d, done_q, done_d;

  always_comb begin
    lim    = (ext_to == 2'b11) ? CW'(WIN_TICKS) : CW'(LIM_LONG);
    cnt_d  = cnt_q;
    seen_d = seen_q;
    done_d = 1'b0;
    if (!active || addr_chg) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (cnt_q >= lim - 1'b1) begin
      cnt_d  = '0;
      seen_d = 1'b0;
      done_d = !(seen_q || dup_evt);
    end else begin
      cnt_d  = cnt_q + 1'b1;
      seen_d = seen_q || dup_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      done_q <= done_d;
    end
  end

  assign win_done = done_q;
endmodule

// File: rtl/dupid_status.sv
module dupid_status
  import dupid_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dup_evt,
  input  logic  tok_vld,
  input  logic  rx_act,
  input  logic  join_evt,
  input  logic  tx_en,
  input  logic  stat_rd,
  output stat_t stat
);
  stat_t st_q, st_d;

  always_comb begin
    st_d.dup = dup_evt || (st_q.dup && !stat_rd);
    st_d.tok = tok_vld || (st_q.tok && !stat_rd);
    st_d.rcn = (join_evt && tx_en) || (st_q.rcn && !stat_rd);
    st_d.rxa = rx_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign stat = st_q;
endmodule

// File: rtl/dupid_monitor.sv
module dupid_monitor
  import dupid_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int RSP_TO    = 4,
  parameter int WIN_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              tx_en,
  input  logic [1:0]        ext_to,
  input  logic              tok_vld,
  input  logic [ADDR_W-1:0] tok_dst,
  input  logic              rsp_vld,
  input  logic              rx_act,
  input  logic              join_evt,
  input  logic              stat_rd,
  output logic [7:0]        stat_byte,
  output logic              win_done
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_chg, active, dup_evt, armed;
  stat_t             stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) addr_q <= '0;
    else             addr_q <= node_addr;
  end

  always_comb begin
    addr_chg = (node_addr != addr_q);
    active   = (node_addr != '0) && !tx_en;
  end

  dupid_match #(.ADDR_W(ADDR_W), .RSP_TO(RSP_TO)) u_match (
    .clk(clk), .rst_n(rst_sync_n), .active(active), .addr_chg(addr_chg),
    .node_addr(node_addr), .tok_vld(tok_vld), .tok_dst(tok_dst),
    .rsp_vld(rsp_vld), .dup_evt(dup_evt), .armed(armed)
  );

  dupid_window #(.WIN_TICKS(WIN_TICKS)) u_win (
    .clk(clk), .rst_n(rst_sync_n), .active(active), .addr_chg(addr_chg),
    .ext_to(ext_to), .dup_evt(dup_evt), .win_done(win_done)
  );

  dupid_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .dup_evt(dup_evt), .tok_vld(tok_vld),
    .rx_act(rx_act), .join_evt(join_evt), .tx_en(tx_en),
    .stat_rd(stat_rd), .stat(stat)
  );

  assign stat_byte = {4'b0000, stat};
endmodule

// File: rtl/dupid_monitor_chk.sv
module dupid_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       tok_vld,
  input logic       rsp_vld,
  input logic       armed,
  input logic       join_evt,
  input logic       stat_rd,
  input logic [7:0] stat_byte,
  input logic       win_done
);
  assert_dup_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_byte[0]) |-> $past(rsp_vld && armed && !tx_en));

  assert_no_dup_txen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !stat_byte[0]) |=> !stat_byte[0]);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tok_vld) |=> !stat_byte[1]);

  assert_tok_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tok_vld |=> stat_byte[1]);

  assert_join_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (join_evt && tx_en) |=> stat_byte[3]);

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);
endmodule

bind dupid_monitor dupid_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tx_en(tx_en), .tok_vld(tok_vld),
  .rsp_vld(rsp_vld), .armed(armed), .join_evt(join_evt), .stat_rd(stat_rd),
  .stat_byte(stat_byte), .win_done(win_done)
);

// File: tb/sim_dupid_monitor.sv
`timescale 1ns/1ps
module sim_dupid_monitor;
  localparam int WIN = 64;
  localparam int RTO = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] node_addr, tok_dst, stat_byte;
  logic       tx_en, tok_vld, rsp_vld, rx_act, join_evt, stat_rd, win_done;
  logic [1:0] ext_to;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dupid_monitor #(.ADDR_W(8), .RSP_TO(RTO), .WIN_TICKS(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .tx_en(tx_en),
    .ext_to(ext_to), .tok_vld(tok_vld), .tok_dst(tok_dst), .rsp_vld(rsp_vld),
    .rx_act(rx_act), .join_evt(join_evt), .stat_rd(stat_rd),
    .stat_byte(stat_byte), .win_done(win_done)
  );

  // entry: {destination[7:0], response gap in edges[3:0], expected duplicate bit}
  localparam logic [12:0] VEC [7] = '{
    {8'h2A, 4'd1, 1'b1}, {8'h2A, 4'd3, 1'b1}, {8'h2A, 4'd4, 1'b1},
    {8'h2A, 4'd5, 1'b0}, {8'h2A, 4'd9, 1'b0}, {8'h2B, 4'd1, 1'b0},
    {8'hAA, 4'd2, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_status();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask

  task automatic send_tok(input logic [7:0] dst);
    tok_dst = dst; tok_vld = 1'b1; tick(); tok_vld = 1'b0;
  endtask

  task automatic send_rsp();
    rsp_vld = 1'b1; tick(); rsp_vld = 1'b0;
  endtask

  // rewrite address, then count edges until the window pulse
  task automatic measure(input logic [7:0] addr, output int n);
    node_addr = addr;
    tick();
    n = 0;
    for (int i = 0; i < 400; i++) begin
      tick();
      n++;
      if (win_done) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int pulses;
    rst_n = 1'b0; node_addr = 8'h00; tx_en = 1'b0; ext_to = 2'b11;
    tok_vld = 1'b0; tok_dst = 8'h00; rsp_vld = 1'b0; rx_act = 1'b0;
    join_evt = 1'b0; stat_rd = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 status after reset", stat_byte, 0);
    check("R1 pulse after reset", win_done, 0);

    // asleep: address 0, token to 0 then response
    send_tok(8'h00);
    check("R6 token seen while asleep", stat_byte[1], 1);
    send_rsp();
    check("R4 no duplicate while asleep", stat_byte[0], 0);
    clear_status();

    node_addr = 8'h2A;
    repeat (3) tick();

    // table of tokens and response gaps
    foreach (VEC[i]) begin
      clear_status();
      repeat (RTO + 2) tick();
      send_tok(VEC[i][12:5]);
      repeat (int'(VEC[i][4:1]) - 1) tick();
      send_rsp();
      check(VEC[i][0] ? "R2 response in time" : "R3 late or foreign response",
            stat_byte[0], VEC[i][0]);
    end

    // transmitter enabled: detection off
    clear_status();
    tx_en = 1'b1;
    tick();
    send_tok(8'h2A);
    send_rsp();
    check("R4 no duplicate with tx_en", stat_byte[0], 0);
    tx_en = 1'b0;
    tick();

    // read clears, set wins
    send_tok(8'h2A);
    send_rsp();
    check("R2 duplicate before read", stat_byte[0], 1);
    clear_status();
    check("R5 read clears status", stat_byte & 8'h0B, 0);
    tok_dst = 8'h55; tok_vld = 1'b1; stat_rd = 1'b1;
    tick();
    tok_vld = 1'b0; stat_rd = 1'b0;
    check("R5 set wins over read", stat_byte[1], 1);
    clear_status();

    // receive activity bit
    rx_act = 1'b1; tick();
    check("R7 activity follows input", stat_byte[2], 1);
    clear_status();
    check("R7 read leaves activity", stat_byte[2], 1);
    rx_act = 1'b0; tick();
    check("R7 activity drops", stat_byte[2], 0);

    // own reconfiguration bit
    join_evt = 1'b1; tick(); join_evt = 1'b0;
    check("R8 join ignored without tx_en", stat_byte[3], 0);
    tx_en = 1'b1;
    join_evt = 1'b1; tick(); join_evt = 1'b0;
    check("R8 join sets reconfiguration", stat_byte[3], 1);
    clear_status();
    check("R5 read clears reconfiguration", stat_byte[3], 0);
    tx_en = 1'b0;
    tick();

    // address rewrite drops an armed token
    clear_status();
    send_tok(8'h2A);
    node_addr = 8'h2B;
    tick();
    send_rsp();
    check("R10 rewrite drops armed token", stat_byte[0], 0);

    // window lengths
    ext_to = 2'b11;
    measure(8'h31, n);
    check("R9 short window length", n, WIN);
    ext_to = 2'b01;
    measure(8'h32, n);
    check("R9 long window length", n, 2 * WIN);
    ext_to = 2'b11;

    // restart mid-window
    node_addr = 8'h33;
    tick();
    pulses = 0;
    repeat (20) begin tick(); if (win_done) pulses++; end
    measure(8'h34, n);
    check("R10 restart mid-window length", n, WIN);
    check("R10 no early pulse", pulses, 0);

    // duplicate inside window suppresses pulse
    node_addr = 8'h35;
    tick();
    pulses = 0;
    send_tok(8'h35);
    send_rsp();
    repeat (WIN + 3) begin tick(); if (win_done) pulses++; end
    check("R11 no pulse after duplicate", pulses, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule